// File: doc/BRIEF.md
# Threaded Reorder Buffer Partition Allocator

The block keeps track of reorder buffer space that several hardware threads of a simultaneous multithreading core share. The buffer is cut into equal partitions of consecutive entries. Every thread fills entries in program order along its own chain of partitions, retires from the oldest end of that chain, and can be flushed without touching any other thread. Entries of two threads never share a partition, so the retire and flush of one thread stay separate from every other thread.

Two modes are available. In the fixed mode each thread may only use the partitions of its own contiguous slice of the buffer (P/T partitions), so no thread can be starved by another. In the shared mode any free partition can be handed to any thread that needs one. This uses the buffer better, but one busy thread can take every free partition and block the others. The mode is meant to change only while the block is held in reset. Entry payloads and renaming live elsewhere: this block only produces entry indices, grants and occupancy.

Default geometry is 2 threads, 4 partitions and 4 entries per partition. An entry index is `partition * 4 + slot`, which is 4 bits wide.

Top module: `smt_rob_partitioner`

## Requirements
- R1: After reset every thread has occupancy 0 and owns exactly its home partition t*(P/T). The free-partition count is P-T (2 with the defaults).
- R2: A granted dispatch returns the index partition*DEPTH+slot. Within a partition, slots are handed out 0,1,2,... in dispatch order, and the grant and index are valid in the same cycle as the request.
- R3: A commit on a non-empty thread returns that thread's oldest index, in dispatch order, independently of the other threads. A commit on an empty thread is ignored and leaves its occupancy unchanged.
- R4: When a thread's current partition is full and it asks to dispatch in shared mode, it receives the lowest-numbered free partition, and the entry goes to slot 0 of that partition.
- R5: In fixed mode a thread only receives free partitions from its own range [t*P/T, (t+1)*P/T). This holds even when partitions outside that range are free.
- R6: A dispatch is not granted while the thread's current partition is full and no eligible partition is free. In shared mode this lets one thread starve another.
- R7: At most one new partition is handed out per cycle. When several threads need one in the same cycle, a rotating priority picks the winner, starting at thread 0 after reset, and the last winner has the lowest priority next time.
- R8: A partition goes back to the free pool in the cycle its last entry commits, provided the thread still holds another partition. A thread always keeps at least one partition.
- R9: A flush of one thread clears its occupancy, keeps its oldest partition and frees all its other partitions, effective at the next clock edge. A dispatch or commit requested by that thread in the flush cycle is not granted. Other threads are not affected.
- R10: When a thread's last entry commits with no dispatch in the same cycle, the next dispatch of that thread reuses slot 0 of the partition it kept. The same applies after a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dynMode | input | 1 | 1 = shared pool of partitions, 0 = fixed per-thread slices |
| dispReq | input | 2 | Per-thread request to allocate one entry |
| commitReq | input | 2 | Per-thread request to retire the oldest entry |
| squash | input | 2 | Per-thread flush of all in-flight entries |
| dispGnt | output | 2 | Per-thread dispatch grant, same cycle |
| dispIdx | output | 8 | Per-thread index of the granted entry, 4 bits per thread |
| cmtIdx | output | 8 | Per-thread index of the oldest entry, 4 bits per thread |
| occFlat | output | 10 | Per-thread entry count, 5 bits per thread |
| freeCnt | output | 3 | Number of partitions in the free pool |

## Verification
If a partition chain is corrupted, a later dispatch soon returns an index that falls outside the expected partition, or a commit returns indices out of dispatch order. This is seen at most DEPTH entries after the fault. A partition that is leaked or freed twice shows up one cycle later in freeCnt, and it also shows up as a grant that should have been refused (or the other way round) the next time a thread fills its partition. A wrong arbitration pointer shows up the next time two threads need a partition in the same cycle, because the wrong thread is granted.

// File: rtl/rob_part_pkg.sv
package rob_part_pkg;
  localparam int THR_N      = 2;
  localparam int PART_N     = 4;
  localparam int PART_DEPTH = 4;

  localparam int TW   = (THR_N > 1) ? $clog2(THR_N) : 1;
  localparam int PW   = $clog2(PART_N);
  localparam int OW   = $clog2(PART_DEPTH);
  localparam int IW   = PW + OW;
  localparam int LW   = $clog2(PART_N + 1);
  localparam int CW   = $clog2(PART_N * PART_DEPTH + 1);
  localparam int SPAN = PART_N / THR_N;

  typedef struct packed {
    logic [THR_N-1:0] grant;
    logic [PW-1:0]    part;
  } allocStrobe_t;
endpackage

// File: rtl/rob_part_chains.sv
module rob_part_chains
  import rob_part_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [THR_N-1:0]        dispReq,
  input  logic [THR_N-1:0]        commitReq,
  input  logic [THR_N-1:0]        squash,
  input  allocStrobe_t            alloc,
  output logic [THR_N-1:0]        needNew,
  output logic [PART_N-1:0]       releaseMask,
  output logic [THR_N-1:0]        dispGnt,
  output logic [THR_N*IW-1:0]     dispIdx,
  output logic [THR_N*IW-1:0]     cmtIdx,
  output logic [THR_N*CW-1:0]     occFlat
);
  localparam logic [OW:0]   SLOT_FULL = (OW+1)'(PART_DEPTH);
  localparam logic [OW:0]   SLOT_LAST = (OW+1)'(PART_DEPTH - 1);
  localparam logic [LW-1:0] LEN_ONE   = LW'(1);

  logic [THR_N*PART_N-1:0] relFlat;

  always_comb begin
    releaseMask = '0;
    for (int t = 0; t < THR_N; t++) releaseMask |= relFlat[t*PART_N +: PART_N];
  end

  for (genvar t = 0; t < THR_N; t++) begin : gThr
    localparam logic [PW-1:0] HOME = PW'(t * SPAN);

    logic [PW-1:0]     chainQ [PART_N];
    logic [PW-1:0]     chainN [PART_N];
    logic [LW-1:0]     lenQ, lenN, lastSlot;
    logic [OW:0]       headQ, headN, tailQ, tailN;
    logic [CW-1:0]     occQ, occN;
    logic [PART_N-1:0] relMask;
    logic              tailFull, active, need, gnt, append, cmtDo, pop, goesEmpty;
    logic [PW-1:0]     tailPart;

    assign lastSlot  = lenQ - LEN_ONE;
    assign tailPart  = chainQ[lastSlot[PW-1:0]];
    assign tailFull  = (tailQ == SLOT_FULL);
    assign active    = dispReq[t] & ~squash[t];
    assign need      = active & tailFull;
    assign gnt       = active & (~tailFull | alloc.grant[t]);
    assign append    = need & alloc.grant[t];
    assign cmtDo     = commitReq[t] & ~squash[t] & (occQ != '0);
    assign pop       = cmtDo & (headQ == SLOT_LAST) & ((lenQ > LEN_ONE) | append);
    assign goesEmpty = cmtDo & (occQ == CW'(1)) & ~gnt;

    always_comb begin
      chainN  = chainQ;
      lenN    = lenQ;
      relMask = '0;
      if (append) begin
        chainN[lenQ[PW-1:0]] = alloc.part;
        lenN = lenQ + LEN_ONE;
      end
      if (pop) begin
        relMask[chainQ[0]] = 1'b1;
        for (int k = 0; k < PART_N - 1; k++) chainN[k] = chainN[k+1];
        lenN = lenN - LEN_ONE;
      end
      headN = pop ? '0 : headQ + (OW+1)'(cmtDo);
      tailN = append ? (OW+1)'(1) : tailQ + (OW+1)'(gnt & ~tailFull);
      occN  = occQ + CW'(gnt) - CW'(cmtDo);
      if (goesEmpty) begin
        headN = '0;
        tailN = '0;
      end
      if (squash[t]) begin
        relMask = '0;
        for (int k = 1; k < PART_N; k++)
          if (LW'(k) < lenQ) relMask[chainQ[k]] = 1'b1;
        chainN = chainQ;
        lenN   = LEN_ONE;
        headN  = '0;
        tailN  = '0;
        occN   = '0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int k = 0; k < PART_N; k++) chainQ[k] <= (k == 0) ? HOME : '0;
        lenQ  <= LEN_ONE;
        headQ <= '0;
        tailQ <= '0;
        occQ  <= '0;
      end else begin
        chainQ <= chainN;
        lenQ   <= lenN;
        headQ  <= headN;
        tailQ  <= tailN;
        occQ   <= occN;
      end
    end

    assign needNew[t]                 = need;
    assign dispGnt[t]                 = gnt;
    assign relFlat[t*PART_N +: PART_N] = relMask;
    assign dispIdx[t*IW +: IW]        = tailFull ? {alloc.part, OW'(0)} : {tailPart, tailQ[OW-1:0]};
    assign cmtIdx[t*IW +: IW]         = {chainQ[0], headQ[OW-1:0]};
    assign occFlat[t*CW +: CW]        = occQ;

    AST_KEEP_ONE_PART: assert property (@(posedge clk) disable iff (!rstN)
      (lenQ != '0)); // R8
    AST_OCC_FITS_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
      (int'(occQ) <= int'(lenQ) * PART_DEPTH)); // R2
    AST_SQUASH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
      squash[t] |=> (occQ == '0)); // R9
    AST_EMPTY_COMMIT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
      (occQ == '0 && !dispReq[t] && !squash[t]) |=> (occQ == '0)); // R3
  end
endmodule

// File: rtl/rob_part_alloc.sv
module rob_part_alloc
  import rob_part_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dynMode,
  input  logic [THR_N-1:0]  needNew,
  input  logic [PART_N-1:0] releaseMask,
  output allocStrobe_t      alloc,
  output logic [LW-1:0]     freeCnt
);
  logic [PART_N-1:0] freeQ, takeMask;
  logic [TW-1:0]     rrQ, winner;
  logic              found;
  logic [THR_N-1:0]  candOk;
  logic [PW-1:0]     candPart [THR_N];

  always_comb begin
    for (int t = 0; t < THR_N; t++) begin
      candOk[t]   = 1'b0;
      candPart[t] = '0;
      for (int p = PART_N - 1; p >= 0; p--) begin
        if (freeQ[p] && (dynMode || (p / SPAN) == t)) begin
          candOk[t]   = 1'b1;
          candPart[t] = PW'(p);
        end
      end
    end
  end

  always_comb begin
    alloc    = '0;
    found    = 1'b0;
    winner   = '0;
    takeMask = '0;
    for (int i = 0; i < THR_N; i++) begin
      int c;
      c = (int'(rrQ) + i) % THR_N;
      if (!found && needNew[c] && candOk[c]) begin
        found          = 1'b1;
        winner         = TW'(c);
        alloc.grant[c] = 1'b1;
        alloc.part     = candPart[c];
      end
    end
    if (found) takeMask[alloc.part] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PART_N; p++) freeQ[p] <= ((p % SPAN) != 0);
      rrQ <= '0;
    end else begin
      freeQ <= (freeQ & ~takeMask) | releaseMask;
      if (found) rrQ <= (int'(winner) == THR_N - 1) ? '0 : winner + TW'(1);
    end
  end

  assign freeCnt = LW'($countones(freeQ));

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(alloc.grant)); // R7
  AST_GRANT_IS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (alloc.grant != '0) |-> freeQ[alloc.part]); // R4
  AST_GRANT_ONLY_NEEDY: assert property (@(posedge clk) disable iff (!rstN)
    ((alloc.grant & ~needNew) == '0)); // R6
  AST_STATIC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (!dynMode && alloc.grant != '0) |-> ((int'(alloc.part) / SPAN) == int'(winner))); // R5
  AST_NO_DOUBLE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    ((releaseMask & freeQ) == '0)); // R8
endmodule

// File: rtl/smt_rob_partitioner.sv
module smt_rob_partitioner
  import rob_part_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                dynMode,
  input  logic [THR_N-1:0]    dispReq,
  input  logic [THR_N-1:0]    commitReq,
  input  logic [THR_N-1:0]    squash,
  output logic [THR_N-1:0]    dispGnt,
  output logic [THR_N*IW-1:0] dispIdx,
  output logic [THR_N*IW-1:0] cmtIdx,
  output logic [THR_N*CW-1:0] occFlat,
  output logic [LW-1:0]       freeCnt
);
  allocStrobe_t      alloc;
  logic [THR_N-1:0]  needNew;
  logic [PART_N-1:0] releaseMask;

  rob_part_alloc i_alloc (
    .clk(clk), .rstN(rstN), .dynMode(dynMode), .needNew(needNew),
    .releaseMask(releaseMask), .alloc(alloc), .freeCnt(freeCnt)
  );

  rob_part_chains i_chains (
    .clk(clk), .rstN(rstN), .dispReq(dispReq), .commitReq(commitReq),
    .squash(squash), .alloc(alloc), .needNew(needNew),
    .releaseMask(releaseMask), .dispGnt(dispGnt), .dispIdx(dispIdx),
    .cmtIdx(cmtIdx), .occFlat(occFlat)
  );
endmodule

// File: tb/test_smt_rob_partitioner.sv
module test_smt_rob_partitioner;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dynMode = 1'b0;
  logic [1:0] dispReq = '0, commitReq = '0, squash = '0;
  logic [1:0] dispGnt;
  logic [7:0] dispIdx, cmtIdx;
  logic [9:0] occFlat;
  logic [2:0] freeCnt;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  smt_rob_partitioner i_smt_rob_partitioner (
    .clk(clk), .rstN(rstN), .dynMode(dynMode), .dispReq(dispReq),
    .commitReq(commitReq), .squash(squash), .dispGnt(dispGnt),
    .dispIdx(dispIdx), .cmtIdx(cmtIdx), .occFlat(occFlat), .freeCnt(freeCnt)
  );

  function automatic int dIdx(int t); return int'(dispIdx[t*4 +: 4]); endfunction
  function automatic int cIdx(int t); return int'(cmtIdx[t*4 +: 4]); endfunction
  function automatic int occ(int t);  return int'(occFlat[t*5 +: 5]); endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setIn(bit d0, bit d1, bit c0, bit c1, bit s0, bit s1);
    dispReq = {d1, d0}; commitReq = {c1, c0}; squash = {s1, s0};
    #2;
  endtask

  task automatic tick();
    @(negedge clk);
    dispReq = '0; commitReq = '0; squash = '0;
    #1;
  endtask

  task automatic doReset(bit mode);
    dynMode = mode; dispReq = '0; commitReq = '0; squash = '0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  task automatic testFixedMode();
    doReset(1'b0);
    chk("R1 occ t0", occ(0), 0);
    chk("R1 occ t1", occ(1), 0);
    chk("R1 free count", int'(freeCnt), 2);
    for (int k = 0; k < 8; k++) begin
      setIn(1, 0, 0, 0, 0, 0);
      chk("R2 fixed dispatch grant", int'(dispGnt[0]), 1);
      chk("R2/R5 fixed dispatch index", dIdx(0), k);
      tick();
    end
    chk("R5 free count after own-range take", int'(freeCnt), 1);
    setIn(1, 0, 0, 0, 0, 0);
    chk("R5/R6 no grant outside own range", int'(dispGnt[0]), 0);
    tick();
    chk("R6 occ unchanged", occ(0), 8);
    for (int k = 0; k < 2; k++) begin
      setIn(0, 1, 0, 0, 0, 0);
      chk("R2 t1 index", dIdx(1), 8 + k);
      tick();
    end
    setIn(0, 0, 1, 1, 0, 0);
    chk("R3 t0 oldest", cIdx(0), 0);
    chk("R3 t1 oldest", cIdx(1), 8);
    tick();
    setIn(0, 0, 0, 1, 0, 0);
    chk("R3 t1 second", cIdx(1), 9);
    tick();
    chk("R3 t1 empty", occ(1), 0);
    setIn(0, 0, 0, 1, 0, 0);
    tick();
    chk("R3 empty commit ignored t1", occ(1), 0);
    chk("R3 other thread untouched", occ(0), 7);
    setIn(0, 1, 0, 0, 0, 0);
    chk("R10 reuse slot 0", dIdx(1), 8);
    tick();
    for (int k = 1; k < 4; k++) begin
      setIn(0, 0, 1, 0, 0, 0);
      chk("R3 t0 order", cIdx(0), k);
      tick();
    end
    chk("R8 partition returned", int'(freeCnt), 2);
    chk("R8 occ t0", occ(0), 4);
    setIn(1, 0, 0, 0, 0, 0);
    chk("R5 regrant own partition", dIdx(0), 0);
    chk("R5 regrant grant", int'(dispGnt[0]), 1);
    tick();
    chk("R5 free after regrant", int'(freeCnt), 1);
  endtask

  task automatic testSharedStarve();
    doReset(1'b1);
    for (int k = 0; k < 12; k++) begin
      setIn(1, 0, 0, 0, 0, 0);
      chk("R4 shared grant", int'(dispGnt[0]), 1);
      chk("R4 shared index", dIdx(0), (k < 8) ? k : k + 4);
      tick();
    end
    setIn(1, 0, 0, 0, 0, 0);
    chk("R6 pool empty t0", int'(dispGnt[0]), 0);
    tick();
    chk("R6 free zero", int'(freeCnt), 0);
    for (int k = 0; k < 4; k++) begin
      setIn(0, 1, 0, 0, 0, 0);
      chk("R2 t1 home index", dIdx(1), 8 + k);
      tick();
    end
    setIn(0, 1, 0, 0, 0, 0);
    chk("R6 t1 starved", int'(dispGnt[1]), 0);
    tick();
    setIn(1, 0, 0, 0, 1, 0);
    chk("R9 no grant while flushing", int'(dispGnt[0]), 0);
    tick();
    chk("R9 occ t0 cleared", occ(0), 0);
    chk("R9 occ t1 kept", occ(1), 4);
    chk("R9 partitions freed", int'(freeCnt), 2);
    setIn(0, 1, 0, 0, 0, 0);
    chk("R4 lowest free", dIdx(1), 4);
    chk("R4 grant after flush", int'(dispGnt[1]), 1);
    tick();
    setIn(1, 0, 0, 0, 0, 0);
    chk("R10 restart after flush", dIdx(0), 0);
    tick();
  endtask

  task automatic testRotation();
    doReset(1'b1);
    for (int k = 0; k < 4; k++) begin
      setIn(1, 1, 0, 0, 0, 0);
      chk("R2 parallel t0", dIdx(0), k);
      chk("R2 parallel t1", dIdx(1), 8 + k);
      tick();
    end
    setIn(1, 1, 0, 0, 0, 0);
    chk("R7 first winner t0", int'(dispGnt[0]), 1);
    chk("R7 first loser t1", int'(dispGnt[1]), 0);
    chk("R7 t0 index", dIdx(0), 4);
    tick();
    setIn(0, 0, 0, 0, 1, 0);
    tick();
    chk("R9 free after flush", int'(freeCnt), 2);
    for (int k = 0; k < 4; k++) begin
      setIn(1, 0, 0, 0, 0, 0);
      tick();
    end
    setIn(1, 1, 0, 0, 0, 0);
    chk("R7 rotated winner t1", int'(dispGnt[1]), 1);
    chk("R7 rotated loser t0", int'(dispGnt[0]), 0);
    chk("R7 t1 index", dIdx(1), 4);
    tick();
    setIn(1, 0, 0, 0, 0, 0);
    chk("R4 t0 next free", dIdx(0), 12);
    tick();
  endtask

  initial begin
    testFixedMode();
    testSharedStarve();
    testRotation();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule